// File: doc/BRIEF.md
# Resettable Square-Wave Rate Generator

This block drives a square-wave output pin from a 32768 Hz clock enable. It has its own free-running binary prescaler, separate from any timekeeping counter, so it is not disturbed when time is rewritten. A four-bit rate code selects one of sixteen output frequencies, from 32768 Hz down to 0.5 Hz.

A synchronisation input clears the slow prescaler stages and holds them at zero. These are the stages that make frequencies below 4096 Hz. When the input is released, the slow output restarts from a known phase, so software can line the wave up with other events. The fast stages keep running throughout.

The pin has three behaviours:
- It carries the selected wave when both the output enable and the oscillator enable are set.
- It is driven low when either of those enables is clear.
- It is released (output enable low) while a power-fail flag is raised.

Top module: `sqw_rate_gen`

## Requirements
- R1: After reset the prescaler count is zero, `wave` is 0, and `wave_oe` equals the inverse of `pwr_fail`.
- R2: With rate code 0, `wave` equals the value `tick_32k` had one clock earlier. This is the 32768 Hz setting.
- R3: With rate code n (1 to 15), `wave` equals bit n of the prescaler count as it stood one clock earlier. This gives 8192 Hz for code 1, 4096 Hz for code 2, and so on down to 0.5 Hz for code 15.
- R4: The 16-bit prescaler count advances by one on each clock where both `tick_32k` and `osc_en` are 1, and holds its value on every other clock. Writes elsewhere in the system have no effect on it.
- R5: While `sync_hold` is 1, count bits 15..3 are cleared and held at 0. Count bits 2..0 keep counting, so codes 0, 1 and 2 run on unchanged, and codes 3 to 15 output 0.
- R6: When `sync_hold` falls, count bits 15..3 resume from 0. They increment on each carry out of bits 2..0.
- R7: When `out_en` is 0, `wave` is 0 on the following clock.
- R8: When `osc_en` is 0, `wave` is 0 on the following clock, and the count is frozen.
- R9: While `pwr_fail` is 1, `wave_oe` is 0 and `wave` is 0 on the following clock. While `pwr_fail` is 0, `wave_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_32k | input | 1 | Clock enable at 32768 Hz; its level is the 32768 Hz phase |
| rate_sel | input | 4 | Output frequency code |
| out_en | input | 1 | Wave output enable; 0 forces the output low |
| osc_en | input | 1 | Oscillator running; 0 stops the prescaler and forces the output low |
| sync_hold | input | 1 | Clears and holds the prescaler stages below 4096 Hz |
| pwr_fail | input | 1 | Power-fail flag; releases the pin |
| wave | output | 1 | Square-wave level (registered) |
| wave_oe | output | 1 | Pin driver enable; 0 means high impedance |

## Verification
The assertions assume that every input is synchronous to `clk` and held stable across each rising edge. They also assume `tick_32k` is a level whose steps only mark prescaler advances, with no further timing rules.

The bench changes inputs only on falling edges. It drives `tick_32k` in four patterns: idle, every clock, every third clock, and a pseudo-random pattern. The random pattern exercises the assertions on uneven advance spacing.

Reset is released with the enables low and no ticks, so the two-stage internal reset release cannot leave the count out of step.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned SQW_CNT_W    = 16;
  localparam int unsigned SQW_HOLD_LSB = 3;
  localparam int unsigned SQW_SEL_W    = $clog2(SQW_CNT_W);
  typedef logic [SQW_SEL_W-1:0] sqw_rate_t;
endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned HOLD_LSB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt
);
  localparam int unsigned HI_W = CNT_W - HOLD_LSB;

  logic [HOLD_LSB-1:0] lo_q, lo_d;
  logic [HI_W-1:0]     hi_q, hi_d;
  logic                carry;

  // next state
  always_comb begin
    carry = adv & (&lo_q);
    lo_d  = adv ? lo_q + HOLD_LSB'(1) : lo_q;
    if (hold) hi_d = '0;
    else      hi_d = hi_q + HI_W'(carry);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt = {hi_q, lo_q};

  // R5
  hold_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt[CNT_W-1:HOLD_LSB] == '0));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !hold) |=> $stable(cnt));

  // R4
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !hold) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R5
  fast_stages_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && hold) |=> (cnt[HOLD_LSB-1:0] == $past(cnt[HOLD_LSB-1:0]) + HOLD_LSB'(1)));
endmodule

// File: rtl/sqw_rate_mux.sv
module sqw_rate_mux #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  localparam int unsigned N_TAP = 1 << SEL_W;

  logic [N_TAP-1:0] taps;

  for (genvar k = 0; k < N_TAP; k++) begin : g_tap
    if (k == 0) begin : g_raw
      assign taps[k] = tick;
    end else if (k < CNT_W) begin : g_bit
      assign taps[k] = cnt[k];
    end else begin : g_none
      assign taps[k] = 1'b0;
    end
  end

  assign tap = taps[sel];
endmodule

// File: rtl/sqw_pin_ctrl.sv
module sqw_pin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  input  logic run_en,
  input  logic pwr_fail,
  output logic wave,
  output logic wave_oe
);
  logic wave_q, wave_d;

  // next state
  always_comb begin
    wave_d = tap & run_en & ~pwr_fail;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave    = wave_q;
  assign wave_oe = ~pwr_fail;

  // R9
  pwrfail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !wave_q);

  // R7
  stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !wave_q);
endmodule

// File: rtl/sqw_rate_gen.sv
module sqw_rate_gen
  import sqw_pkg::*;
#(
  parameter int unsigned CNT_W    = SQW_CNT_W,
  parameter int unsigned HOLD_LSB = SQW_HOLD_LSB,
  parameter int unsigned SEL_W    = SQW_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_32k,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             out_en,
  input  logic             osc_en,
  input  logic             sync_hold,
  input  logic             pwr_fail,
  output logic             wave,
  output logic             wave_oe
);
  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic             adv;
  logic             run_en;
  logic             tap;
  logic [CNT_W-1:0] cnt;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign adv    = tick_32k & osc_en;
  assign run_en = out_en & osc_en;

  sqw_prescaler #(.CNT_W(CNT_W), .HOLD_LSB(HOLD_LSB)) u_presc (
    .clk  (clk),
    .rst_n(rst_n_int),
    .adv  (adv),
    .hold (sync_hold),
    .cnt  (cnt)
  );

  sqw_rate_mux #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_mux (
    .cnt (cnt),
    .tick(tick_32k),
    .sel (rate_sel),
    .tap (tap)
  );

  sqw_pin_ctrl u_pin (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tap     (tap),
    .run_en  (run_en),
    .pwr_fail(pwr_fail),
    .wave    (wave),
    .wave_oe (wave_oe)
  );

  // R2
  raw_phase_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rate_sel == '0 && run_en && !pwr_fail) |=> (wave == $past(tick_32k)));

  // R8
  osc_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !osc_en |=> (!wave && $stable(cnt)));
endmodule

// File: tb/sqw_rate_gen_tb.sv
module sqw_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       out_en = 1'b0;
  logic       osc_en = 1'b0;
  logic       sync_hold = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       wave, wave_oe;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  checking = 1'b0;
  bit  done = 1'b0;
  string cur_req = "R1";
  int  tmode = 0;
  int  tphase = 0;
  logic [7:0] lfsr = 8'hA5;

  int   m_cnt;
  logic exp_w;

  always #4 clk = ~clk;

  sqw_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
    .out_en(out_en), .osc_en(osc_en), .sync_hold(sync_hold),
    .pwr_fail(pwr_fail), .wave(wave), .wave_oe(wave_oe)
  );

  // behavioural reference: a plain integer count of advances
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      exp_w = 1'b0;
    end else begin
      if (pwr_fail)               exp_w = 1'b0;
      else if (out_en && osc_en)  exp_w = (rate_sel == 0) ? tick_32k : ((m_cnt >> rate_sel) & 1) != 0;
      else                        exp_w = 1'b0;
      if (tick_32k && osc_en) m_cnt = (m_cnt + 1) % 65536;
      if (sync_hold)          m_cnt = m_cnt % 8;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, then step the tick pattern
  always @(negedge clk) begin
    if (checking) begin
      check(cur_req, wave, exp_w, "wave");
      check(cur_req, wave_oe, !pwr_fail, "wave_oe");
    end
    tphase++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (tmode)
      1: tick_32k = ~tick_32k;
      2: tick_32k = (tphase % 3 == 0);
      3: tick_32k = lfsr[0];
      default: tick_32k = 1'b0;
    endcase
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(5);
    // R1: reset state
    check("R1", wave, 1'b0, "wave after reset");
    check("R1", wave_oe, 1'b1, "wave_oe after reset");
    checking = 1'b1;
    out_en = 1'b1;
    osc_en = 1'b1;
    tmode  = 1;
    // R2: raw 32768 Hz phase
    cur_req = "R2"; rate_sel = 4'd0; run(400);
    // R3: each divided tap
    cur_req = "R3";
    for (int c = 1; c < 15; c++) begin rate_sel = 4'(c); run(400); end
    tmode = 2;
    for (int c = 1; c < 5; c++) begin rate_sel = 4'(c); run(400); end
    tmode = 1; rate_sel = 4'd15; run(70000);
    // R8: oscillator stopped
    cur_req = "R8"; rate_sel = 4'd1; osc_en = 1'b0; run(200);
    // R4: count frozen meanwhile, resumes; irregular advance
    cur_req = "R4"; osc_en = 1'b1; run(200);
    tmode = 3; rate_sel = 4'd2; run(500); rate_sel = 4'd5; run(500);
    // R5: hold clears slow stages, fast ones run
    cur_req = "R5"; tmode = 1; sync_hold = 1'b1;
    rate_sel = 4'd2; run(300);
    rate_sel = 4'd3; run(300);
    rate_sel = 4'd9; run(300);
    rate_sel = 4'd1; run(100);
    // R6: release from reset phase
    cur_req = "R6"; rate_sel = 4'd4; sync_hold = 1'b0; run(300);
    rate_sel = 4'd6; run(300);
    // R7: output enable off
    cur_req = "R7"; out_en = 1'b0; run(300); out_en = 1'b1; run(100);
    // R9: power fail releases pin
    cur_req = "R9"; pwr_fail = 1'b1; run(300); pwr_fail = 1'b0; run(200);
    checking = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule